// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the system clock into the time base of a CAN bit. A programmable prescaler makes a time-quantum tick. A segment sequencer then walks each bit through five parts: a one-quantum sync segment, a leading jump-width segment, time segment 1, time segment 2 and a trailing jump-width segment. Both jump-width segments are as long as the programmed jump width. The receive line is sampled where time segment 1 ends. The block gives a one-clock start-of-bit pulse, a one-clock sample pulse with the sampled level, the quantum tick and the number of the current segment.

Two configuration registers are loaded through a small write port while the init input is high. Init also holds the timing counters at the start of a bit. The receive line's recessive-to-dominant edges keep the bit aligned. An edge on an idle bus restarts the bit at once. An edge inside a bit moves the sample point later or ends the bit sooner, by at most the programmed jump width.

Top module: `can_bit_timer`

## Requirements
- R1: Configuration register 0 carries the jump-width field in bits 7:6 and the prescaler field in bits 5:0. Configuration register 1 carries the segment-2 field in bits 6:4 and the segment-1 field in bits 3:0. A write changes a register only while init is high. A write while init is low has no effect on the timing.
- R2: One quantum lasts 2*(prescaler+1) clock cycles, and tq_tick is high for exactly one clock per quantum.
- R3: A bit runs through the segments in a fixed order, with seg_id encoded as 0 sync, 1 leading jump width, 2 segment 1, 3 segment 2 and 4 trailing jump width. The sync segment lasts one quantum. Each of the other segments lasts its field plus one quanta. The jump-width field sets both jump-width segments. bit_start pulses for one clock on each entry to sync, so consecutive pulses are a full bit apart.
- R4: sample_pulse is high for one clock, 2*(prescaler+1)*(1+(jw+1)+(seg1+1)) clocks after the bit_start of the same bit.
- R5: rx_sampled takes the level of rx_in at the sample point and does not change at any other time. It is recessive (1) after reset.
- R6: After reset, and while init is high, seg_id is 0 and bit_start, sample_pulse and tq_tick stay low.
- R7: A falling edge on rx_in while bus_idle is high restarts the bit. bit_start shows on the next clock, and the timing of the next sample and of the next bit start is measured from that point.
- R8: A falling edge while bus_idle is low, in quantum k (counted from 1) after the sync segment and before the sample point, delays the sample point and the end of the bit by min(k, jw+1) quanta.
- R9: Such an edge in segment 2 removes the trailing jump-width segment. An edge in the trailing segment ends the bit at the end of the quantum that holds the edge.
- R10: An edge in the sync segment does not change the timing, and at most one correction is made in each bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Configuration enable; holds the timing counters |
| cfg_wr0 | input | 1 | Write strobe for configuration register 0 |
| cfg_wr1 | input | 1 | Write strobe for configuration register 1 |
| cfg_wdata | input | 8 | Configuration write data |
| bus_idle | input | 1 | High while no frame is in progress (falling edges then hard-sync) |
| rx_in | input | 1 | Receive line, 1 recessive, 0 dominant |
| tq_tick | output | 1 | One-clock pulse on the last clock of each quantum |
| bit_start | output | 1 | One-clock pulse at the start of each bit |
| sample_pulse | output | 1 | One-clock pulse at the sample point |
| rx_sampled | output | 1 | Bus level latched at the last sample point |
| seg_id | output | 3 | Current segment number |

## Verification
A corrupted prescaler count or segment length shows up at once in the spacing of bit_start and sample_pulse. The error is a whole number of quanta, visible within the first full bit after init is released. A wrong resync flag or extension only shows after a bus edge, in the next sample or the next bit start. For that reason the edges are placed in known quanta of every segment type, and both following events are timed against values worked out from the fields. Sampling errors show on rx_sampled at the next sample point.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [2:0] {
    SEG_SYNC = 3'd0,
    SEG_JW1  = 3'd1,
    SEG_TS1  = 3'd2,
    SEG_TS2  = 3'd3,
    SEG_JW2  = 3'd4
  } seg_e;

  // last prescaler count of a quantum: a quantum is 2*(p+1) clocks
  function automatic int unsigned quantum_last(int unsigned presc);
    return 2 * (presc + 1) - 1;
  endfunction

  // stretch applied for a late edge, capped by the jump width
  function automatic int unsigned phase_ext(int unsigned pos_q, int unsigned jw_q);
    return (pos_q < jw_q) ? pos_q : jw_q;
  endfunction

  function automatic seg_e next_segment(seg_e s, logic skip_jw2);
    case (s)
      SEG_SYNC: return SEG_JW1;
      SEG_JW1:  return SEG_TS1;
      SEG_TS1:  return SEG_TS2;
      SEG_TS2:  return skip_jw2 ? SEG_SYNC : SEG_JW2;
      default:  return SEG_SYNC;
    endcase
  endfunction

endpackage

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs #(
  parameter int DATA_W = 8,
  parameter int SJW_W  = 2,
  parameter int BRP_W  = 6,
  parameter int TS1_W  = 4,
  parameter int TS2_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              wr0,
  input  logic              wr1,
  input  logic [DATA_W-1:0] wdata,
  output logic [SJW_W-1:0]  sjw,
  output logic [BRP_W-1:0]  brp,
  output logic [TS1_W-1:0]  ts1,
  output logic [TS2_W-1:0]  ts2
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sjw <= '0;
      brp <= '0;
      ts1 <= '0;
      ts2 <= '0;
    end else if (init) begin
      if (wr0) begin
        sjw <= wdata[BRP_W +: SJW_W];
        brp <= wdata[0 +: BRP_W];
      end
      if (wr1) begin
        ts1 <= wdata[0 +: TS1_W];
        ts2 <= wdata[TS1_W +: TS2_W];
      end
    end
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !init |=> $stable({sjw, brp, ts1, ts2})); // R1

endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] q_last,
  output logic             tq_end
);

  logic [CNT_W-1:0] pcnt;

  assign tq_end = !clear && (pcnt == q_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pcnt <= '0;
    else if (clear || tq_end)
      pcnt <= '0;
    else
      pcnt <= pcnt + 1'b1;
  end

  AST_TQ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tq_end |=> !tq_end); // R2

endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
  import can_bt_pkg::*;
#(
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             tq_end,
  input  logic             hsync,
  input  logic             resync_edge,
  input  logic [SJW_W-1:0] sjw,
  input  logic [TS1_W-1:0] ts1,
  input  logic [TS2_W-1:0] ts2,
  input  logic             rx_in,
  output seg_e             seg,
  output logic             bit_start,
  output logic             sample_pulse,
  output logic             rx_sampled
);

  localparam int LEN_W = $clog2((1 << TS1_W) + (1 << SJW_W) + 1) + 1;

  logic [LEN_W-1:0] qcnt, ext, jw_len, cur_len;
  logic             resynced, drop_jw2, cut_now;
  logic             last_q, seg_adv, hit_sample, rs_take, enter_sync;
  seg_e             seg_nxt;

  assign jw_len = LEN_W'(sjw) + 1'b1;

  always_comb begin
    case (seg)
      SEG_SYNC: cur_len = LEN_W'(1);
      SEG_JW1:  cur_len = jw_len;
      SEG_TS1:  cur_len = LEN_W'(ts1) + 1'b1 + ext;
      SEG_TS2:  cur_len = LEN_W'(ts2) + 1'b1;
      default:  cur_len = jw_len;
    endcase
  end

  assign last_q     = (qcnt == cur_len - 1'b1);
  assign seg_adv    = tq_end && (last_q || (seg == SEG_JW2 && cut_now));
  assign seg_nxt    = next_segment(seg, drop_jw2);
  assign enter_sync = hsync || (seg_adv && seg_nxt == SEG_SYNC);
  assign hit_sample = tq_end && (seg == SEG_TS1) && last_q && !hsync;
  assign rs_take    = resync_edge && !resynced && (seg != SEG_SYNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg          <= SEG_SYNC;
      qcnt         <= '0;
      ext          <= '0;
      resynced     <= 1'b0;
      drop_jw2     <= 1'b0;
      cut_now      <= 1'b0;
      bit_start    <= 1'b0;
      sample_pulse <= 1'b0;
      rx_sampled   <= 1'b1;
    end else if (init) begin
      seg          <= SEG_SYNC;
      qcnt         <= '0;
      ext          <= '0;
      resynced     <= 1'b0;
      drop_jw2     <= 1'b0;
      cut_now      <= 1'b0;
      bit_start    <= 1'b0;
      sample_pulse <= 1'b0;
    end else begin
      bit_start    <= enter_sync;
      sample_pulse <= hit_sample;
      if (hit_sample) rx_sampled <= rx_in;
      if (hsync) begin
        seg  <= SEG_SYNC;
        qcnt <= '0;
      end else if (seg_adv) begin
        seg  <= seg_nxt;
        qcnt <= '0;
      end else if (tq_end) begin
        qcnt <= qcnt + 1'b1;
      end
      if (enter_sync) begin
        ext      <= '0;
        resynced <= 1'b0;
        drop_jw2 <= 1'b0;
        cut_now  <= 1'b0;
      end else if (rs_take) begin
        resynced <= 1'b1;
        case (seg)
          SEG_JW1: ext <= LEN_W'(phase_ext(int'(qcnt) + 1, int'(jw_len)));
          SEG_TS1: ext <= LEN_W'(phase_ext(int'(jw_len) + int'(qcnt) + 1, int'(jw_len)));
          SEG_TS2: drop_jw2 <= 1'b1;
          default: cut_now <= 1'b1;
        endcase
      end
    end
  end

  AST_SYNC_ONE_TQ: assert property (@(posedge clk) disable iff (!rst_n || init)
    (seg == SEG_SYNC && tq_end && !hsync) |=> seg == SEG_JW1); // R3
  AST_START_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |-> seg == SEG_SYNC); // R3
  AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pulse |=> !sample_pulse); // R4
  AST_SAMPLE_ENTERS_TS2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pulse |-> seg == SEG_TS2); // R4
  AST_RXS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_sampled) |-> sample_pulse); // R5
  AST_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (seg == SEG_SYNC && !bit_start && !sample_pulse)); // R6
  AST_HSYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> (bit_start && seg == SEG_SYNC)); // R7

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SJW_W  = 2,
  parameter int BRP_W  = 6,
  parameter int TS1_W  = 4,
  parameter int TS2_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              cfg_wr0,
  input  logic              cfg_wr1,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              bus_idle,
  input  logic              rx_in,
  output logic              tq_tick,
  output logic              bit_start,
  output logic              sample_pulse,
  output logic              rx_sampled,
  output logic [2:0]        seg_id
);

  localparam int PCNT_W = BRP_W + 1;

  logic [SJW_W-1:0]  sjw;
  logic [BRP_W-1:0]  brp;
  logic [TS1_W-1:0]  ts1;
  logic [TS2_W-1:0]  ts2;
  logic [PCNT_W-1:0] q_last;
  logic              rx_prev, edge_fall, hsync, resync_edge, tq_end;
  seg_e              seg;

  cbt_cfg_regs #(
    .DATA_W(DATA_W), .SJW_W(SJW_W), .BRP_W(BRP_W), .TS1_W(TS1_W), .TS2_W(TS2_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .init(init), .wr0(cfg_wr0), .wr1(cfg_wr1),
    .wdata(cfg_wdata), .sjw(sjw), .brp(brp), .ts1(ts1), .ts2(ts2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_prev <= 1'b1;
    else        rx_prev <= rx_in;
  end

  assign edge_fall   = rx_prev && !rx_in;
  assign hsync       = edge_fall && bus_idle && !init;
  assign resync_edge = edge_fall && !bus_idle && !init;
  assign q_last      = PCNT_W'(quantum_last(int'(brp)));

  cbt_prescaler #(.CNT_W(PCNT_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .clear(init || hsync), .q_last(q_last), .tq_end(tq_end)
  );

  cbt_seg_fsm #(.SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .init(init), .tq_end(tq_end), .hsync(hsync),
    .resync_edge(resync_edge), .sjw(sjw), .ts1(ts1), .ts2(ts2), .rx_in(rx_in),
    .seg(seg), .bit_start(bit_start), .sample_pulse(sample_pulse),
    .rx_sampled(rx_sampled)
  );

  assign tq_tick = tq_end;
  assign seg_id  = seg;

  AST_NO_TICK_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    init |-> !tq_tick); // R6

endmodule

// File: tb/can_bit_timer_tb.sv
module can_bit_timer_tb;

  logic       clk = 1'b0, rst_n = 1'b0, init = 1'b1;
  logic       cfg_wr0 = 1'b0, cfg_wr1 = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       bus_idle = 1'b0, rx_in = 1'b1;
  logic       tq_tick, bit_start, sample_pulse, rx_sampled;
  logic [2:0] seg_id;

  can_bit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .init(init), .cfg_wr0(cfg_wr0), .cfg_wr1(cfg_wr1),
    .cfg_wdata(cfg_wdata), .bus_idle(bus_idle), .rx_in(rx_in), .tq_tick(tq_tick),
    .bit_start(bit_start), .sample_pulse(sample_pulse), .rx_sampled(rx_sampled),
    .seg_id(seg_id)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  int Q, J, T1, T2, L, S;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic set_cfg(int brp, int sjw, int ts1, int ts2);
    Q = 2 * brp + 2; J = sjw + 1; T1 = ts1 + 1; T2 = ts2 + 1;
    L = 1 + 2 * J + T1 + T2; S = 1 + J + T1;
    @(negedge clk); init = 1'b1; cfg_wr0 = 1'b1; cfg_wdata = 8'((sjw << 6) | brp);
    @(negedge clk); cfg_wr0 = 1'b0; cfg_wr1 = 1'b1; cfg_wdata = 8'((ts2 << 4) | ts1);
    @(negedge clk); cfg_wr1 = 1'b0; rx_in = 1'b1; bus_idle = 1'b0; init = 1'b0;
  endtask

  task automatic wait_bs(output int t);
    @(negedge clk);
    while (bit_start !== 1'b1) @(negedge clk);
    t = cyc;
  endtask

  task automatic wait_sp(output int t);
    @(negedge clk);
    while (sample_pulse !== 1'b1) @(negedge clk);
    t = cyc;
  endtask

  task automatic wait_tick(output int t);
    @(negedge clk);
    while (tq_tick !== 1'b1) @(negedge clk);
    t = cyc;
  endtask

  // plain bit: timing, sampling, and an edge placed inside sync
  task automatic run_plain(bit rxv);
    int t0, t1, ts, a, b;
    wait_bs(t0);
    rx_in = rxv;
    wait_tick(a); wait_tick(b);
    check(b - a == Q, "R2", "quantum length", b - a, Q);
    wait_sp(ts);
    check(ts - t0 == Q * S, rxv ? "R4" : "R4/R10", "sample offset", ts - t0, Q * S);
    check(rx_sampled == rxv, "R5", "sampled level", rx_sampled, rxv);
    wait_bs(t1);
    check(t1 - t0 == Q * L, rxv ? "R3" : "R3/R10", "bit period", t1 - t0, Q * L);
    rx_in = 1'b1;
  endtask

  task automatic run_lengthen();
    int t0, t1, ts, k, e;
    wait_bs(t0);
    rx_in = 1'b1;
    k = int'($urandom % 32'(J + T1));
    e = imin(k + 1, J);
    while (cyc != t0 + Q * (1 + k)) @(negedge clk);
    rx_in = 1'b0;
    wait_sp(ts);
    check(ts - t0 == Q * (S + e), "R8", "late-edge sample offset", ts - t0, Q * (S + e));
    wait_bs(t1);
    check(t1 - t0 == Q * (L + e), "R8", "late-edge bit period", t1 - t0, Q * (L + e));
    rx_in = 1'b1;
  endtask

  task automatic run_shorten(bit in_jw2);
    int t0, t1, m, exp_p;
    wait_bs(t0);
    rx_in = 1'b1;
    if (in_jw2) begin
      m = int'($urandom % 32'(J));
      exp_p = Q * (L - (J - 1 - m));
      while (cyc != t0 + Q * (S + T2 + m)) @(negedge clk);
    end else begin
      m = int'($urandom % 32'(T2));
      exp_p = Q * (L - J);
      while (cyc != t0 + Q * (S + m)) @(negedge clk);
    end
    rx_in = 1'b0;
    wait_bs(t1);
    check(t1 - t0 == exp_p, "R9", in_jw2 ? "edge in trailing jw" : "edge in seg2",
          t1 - t0, exp_p);
    rx_in = 1'b1;
  endtask

  task automatic run_hard_sync();
    int t0, th, ts, t1;
    wait_bs(t0);
    rx_in = 1'b1;
    repeat (Q * 2 + 1) @(negedge clk);
    bus_idle = 1'b1; rx_in = 1'b0;
    @(negedge clk);
    check(bit_start == 1'b1, "R7", "bit_start after idle edge", bit_start, 1);
    check(seg_id == 3'd0, "R7", "segment after idle edge", seg_id, 0);
    th = cyc;
    wait_sp(ts);
    check(ts - th == Q * S, "R7", "sample after hard sync", ts - th, Q * S);
    bus_idle = 1'b0;
    wait_bs(t1);
    check(t1 - th == Q * L, "R7", "bit after hard sync", t1 - th, Q * L);
    rx_in = 1'b1;
  endtask

  initial begin
    int t0, t1, cnt;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(seg_id == 3'd0, "R6", "reset seg_id", seg_id, 0);
    check(bit_start == 1'b0, "R6", "reset bit_start", bit_start, 0);
    check(sample_pulse == 1'b0, "R6", "reset sample_pulse", sample_pulse, 0);
    check(rx_sampled == 1'b1, "R5", "reset rx_sampled", rx_sampled, 1);

    // directed: 2 clocks * 2 per quantum, 8-quantum bit, sample at quantum 5
    set_cfg(1, 1, 1, 0);
    wait_bs(t0); wait_bs(t1);
    check(t1 - t0 == 32, "R1", "field layout bit period", t1 - t0, 32);
    run_plain(1'b1);
    run_plain(1'b0);

    // writes while init low are ignored
    wait_bs(t0);
    cfg_wr0 = 1'b1; cfg_wr1 = 1'b1; cfg_wdata = 8'hFF;
    @(negedge clk); cfg_wr0 = 1'b0; cfg_wr1 = 1'b0;
    wait_bs(t0); wait_bs(t1);
    check(t1 - t0 == Q * L, "R1", "write without init ignored", t1 - t0, Q * L);

    // extremes of the jump width
    set_cfg(0, 3, 0, 0);
    run_plain(1'b1); run_lengthen(); run_shorten(1'b1);
    set_cfg(0, 0, 15, 7);
    run_plain(1'b0); run_lengthen(); run_shorten(1'b0);

    for (int i = 0; i < 6; i++) begin
      set_cfg(int'($urandom % 4), int'($urandom % 4), int'($urandom % 16), int'($urandom % 8));
      run_plain(1'($urandom % 2));
      run_lengthen();
      run_shorten(1'b0);
      run_shorten(1'b1);
      run_hard_sync();
    end

    // init holds the counters
    @(negedge clk); init = 1'b1;
    cnt = 0;
    repeat (40) begin
      @(negedge clk);
      if (bit_start || sample_pulse || tq_tick) cnt++;
    end
    check(cnt == 0, "R6", "pulses during init", cnt, 0);
    check(seg_id == 3'd0, "R6", "seg_id during init", seg_id, 0);
    @(negedge clk); init = 1'b0;
    run_plain(1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule